// File: doc/BRIEF.md
# Byte/Word ALU with Condition Flags

This block is the arithmetic and logic stage of a small CPU. The CPU's registers hold bytes, and pairs of bytes form 16-bit words. The stage takes two operands, a 4-bit operation code, a size select and the current 8-bit flag register. It returns the result and the next value of the flag register. It handles add and subtract, with and without the carry, in byte and word form. It also handles increment and decrement, compare, negate, the four bitwise operations, and decimal correction of packed-BCD sums and differences. The 16-bit word-only step forms add or subtract 1 or 2.

Each operation masks its own flag writes. Bits that an operation does not own leave the block exactly as they came in. The interrupt-mask bit and the two user bits are never written. An operation enters through a valid/ready handshake and lands in a single output register. An input is taken on any rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output register is empty, or when its content is being taken in that same cycle. While `out_valid` is high and `out_ready` is low, the output holds and no input is taken, so back-pressure reaches the producer with no extra cycle of delay.

Top module: `alu_flags_unit`

## Requirements
- R1: An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high, and its outcome appears with `out_valid` high after that edge. While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_result`/`out_ccr` stay stable. When a held result is drained, a new operation can be accepted on the same edge.
- R2: Operation codes are ADD=0, SUB=1, ADDX=2, SUBX=3, INC=4, DEC=5, ADDS=6, SUBS=7, CMP=8, NEG=9, AND=10, OR=11, XOR=12, NOT=13, DAA=14, DAS=15. `in_word`=1 selects 16-bit width only for ADD, SUB and CMP. Every other operation except ADDS/SUBS works on the low byte and returns it zero-extended to 16 bits.
- R3: ADD, SUB and NEG return the sum or difference modulo the width. Carry (bit 0) is the carry or borrow out of the top bit. Overflow (bit 1) is set exactly on signed overflow.
- R4: Half-carry (bit 5) is the carry or borrow out of bit 3 for byte operations, and out of bit 11 for word operations.
- R5: Negative (bit 3) equals the top bit of the width-sized result. Zero (bit 2) is 1 exactly when that result is 0.
- R6: ADDX and SUBX are byte-only and add or subtract the incoming carry flag as well. All five arithmetic flags follow from the combined operation.
- R7: INC and DEC add or subtract 1 on a byte and update negative, zero and overflow. Half-carry and carry pass unchanged.
- R8: CMP sets all five arithmetic flags as SUB would, and returns the first operand unchanged as its result.
- R9: NEG returns 0 minus the first operand (byte), with flags as a subtraction.
- R10: AND, OR, XOR and NOT (NOT inverts the first operand) update negative and zero, clear overflow, and leave half-carry and carry unchanged.
- R11: DAA adds 0x06 when half-carry is set or the low nibble exceeds 9. It adds 0x60 and sets carry when carry is set or the byte exceeds 0x99. DAS subtracts 0x06 when half-carry is set and 0x60 when carry is set, and leaves carry unchanged. Both update negative and zero, and leave half-carry and overflow alone.
- R12: ADDS/SUBS add or subtract a step on the full 16-bit first operand. The step is 2 when bit 1 of the second operand is 1 and 1 otherwise. The flag register is returned unchanged.
- R13: Flag bits 7 (interrupt mask), 6 and 4 (user) always leave equal to their incoming value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_op | input | 4 | Operation code |
| in_word | input | 1 | 1 selects 16-bit width where allowed |
| in_a | input | 16 | First (destination) operand |
| in_b | input | 16 | Second (source) operand or step select |
| in_ccr | input | 8 | Current flag register |
| out_valid | output | 1 | Result held in output register |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 16 | Result value |
| out_ccr | output | 8 | Next flag register value |

## Verification
Two things can happen on the same edge: a held result is drained, and a new operation is captured. The bench provokes this by stalling the output with `out_ready` low while a second operation waits on `in_valid`. It then raises `out_ready` and checks that, one edge later, the second operation's value is present with `out_valid` still high. A second kind of overlap is the flag merge, where one operation writes some flags while others pass through. The sweeps run every operation with flag inputs that have carry, half-carry, mask and user bits both set and clear, and compare all eight bits against an arithmetic model.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;
  localparam int FLAG_W = 8;
  localparam int FL_C   = 0;
  localparam int FL_V   = 1;
  localparam int FL_Z   = 2;
  localparam int FL_N   = 3;
  localparam int FL_U0  = 4;
  localparam int FL_H   = 5;
  localparam int FL_U1  = 6;
  localparam int FL_I   = 7;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,  OP_SUB  = 4'd1,  OP_ADDX = 4'd2,  OP_SUBX = 4'd3,
    OP_INC  = 4'd4,  OP_DEC  = 4'd5,  OP_ADDS = 4'd6,  OP_SUBS = 4'd7,
    OP_CMP  = 4'd8,  OP_NEG  = 4'd9,  OP_AND  = 4'd10, OP_OR   = 4'd11,
    OP_XOR  = 4'd12, OP_NOT  = 4'd13, OP_DAA  = 4'd14, OP_DAS  = 4'd15
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W         = 8,
  parameter int NIB_CARRY = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         c,
  output logic         h,
  output logic         v
);
  logic [W:0]   ext;
  logic [W-1:0] diffbits;

  always_comb begin
    if (sub) ext = {1'b0, x} - {1'b0, y} - {{W{1'b0}}, cin};
    else     ext = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    sum      = ext[W-1:0];
    c        = ext[W];
    diffbits = x ^ y ^ sum;
    h        = diffbits[NIB_CARRY];
    if (sub) v = (x[W-1] != y[W-1]) && (sum[W-1] != x[W-1]);
    else     v = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_flags_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] r
);
  always_comb begin
    unique case (op)
      OP_AND:  r = x & y;
      OP_OR:   r = x | y;
      OP_XOR:  r = x ^ y;
      default: r = ~x;
    endcase
  end
endmodule

// File: rtl/alu_decadj.sv
module alu_decadj #(
  parameter int BW = 8
) (
  input  logic [BW-1:0] x,
  input  logic          sub,
  input  logic          c_in,
  input  logic          h_in,
  output logic [BW-1:0] r,
  output logic          c_out
);
  localparam logic [BW-1:0] LO_FIX = BW'(8'h06);
  localparam logic [BW-1:0] HI_FIX = BW'(8'h60);
  localparam logic [BW-1:0] HI_LIM = BW'(8'h99);

  logic          lo_need, hi_need;
  logic [BW-1:0] corr;

  always_comb begin
    if (sub) begin
      lo_need = h_in;
      hi_need = c_in;
    end else begin
      lo_need = h_in || (x[3:0] > 4'd9);
      hi_need = c_in || (x > HI_LIM);
    end
    corr  = (lo_need ? LO_FIX : '0) | (hi_need ? HI_FIX : '0);
    r     = sub ? (x - corr) : (x + corr);
    c_out = sub ? c_in : hi_need;
  end
endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
  import alu_flags_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_op,
  input  logic              in_word,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [FLAG_W-1:0] in_ccr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic [FLAG_W-1:0] out_ccr
);
  localparam int BYTE_W = DATA_W / 2;

  alu_op_e op;
  assign op = alu_op_e'(in_op);

  logic [DATA_W-1:0] as_x, as_y;
  logic              as_cin, as_sub, use_word, arith_op, keeps_ch;

  always_comb begin
    as_x   = in_a;
    as_y   = in_b;
    as_cin = 1'b0;
    as_sub = 1'b0;
    unique case (op)
      OP_SUB, OP_CMP: as_sub = 1'b1;
      OP_ADDX:        as_cin = in_ccr[FL_C];
      OP_SUBX: begin as_sub = 1'b1; as_cin = in_ccr[FL_C]; end
      OP_INC:         as_y = DATA_W'(1);
      OP_DEC:  begin as_sub = 1'b1; as_y = DATA_W'(1); end
      OP_NEG:  begin as_sub = 1'b1; as_x = '0; as_y = in_a; end
      default: ;
    endcase
    use_word = in_word && (op == OP_ADD || op == OP_SUB || op == OP_CMP);
    arith_op = (op inside {OP_ADD, OP_SUB, OP_ADDX, OP_SUBX, OP_INC, OP_DEC, OP_CMP, OP_NEG});
    keeps_ch = (op == OP_INC || op == OP_DEC);
  end

  logic [BYTE_W-1:0] b_sum;
  logic [DATA_W-1:0] w_sum;
  logic b_c, b_h, b_v, w_c, w_h, w_v;

  alu_addsub #(.W(BYTE_W), .NIB_CARRY(4)) u_byte_as (
    .x(as_x[BYTE_W-1:0]), .y(as_y[BYTE_W-1:0]), .cin(as_cin), .sub(as_sub),
    .sum(b_sum), .c(b_c), .h(b_h), .v(b_v)
  );

  alu_addsub #(.W(DATA_W), .NIB_CARRY(BYTE_W + 4)) u_word_as (
    .x(as_x), .y(as_y), .cin(as_cin), .sub(as_sub),
    .sum(w_sum), .c(w_c), .h(w_h), .v(w_v)
  );

  logic [BYTE_W-1:0] l_res;
  alu_logic #(.W(BYTE_W)) u_logic (
    .op(op), .x(in_a[BYTE_W-1:0]), .y(in_b[BYTE_W-1:0]), .r(l_res)
  );

  logic [BYTE_W-1:0] d_res;
  logic              d_c;
  alu_decadj #(.BW(BYTE_W)) u_decadj (
    .x(in_a[BYTE_W-1:0]), .sub(op == OP_DAS), .c_in(in_ccr[FL_C]),
    .h_in(in_ccr[FL_H]), .r(d_res), .c_out(d_c)
  );

  logic [DATA_W-1:0] step, imm_res;
  assign step    = in_b[1] ? DATA_W'(2) : DATA_W'(1);
  assign imm_res = (op == OP_SUBS) ? (in_a - step) : (in_a + step);

  logic [DATA_W-1:0] nx_res, calc;
  logic [FLAG_W-1:0] nx_ccr;
  logic              calc_n;

  always_comb begin
    nx_ccr = in_ccr;
    calc   = {{(DATA_W-BYTE_W){1'b0}}, b_sum};
    calc_n = b_sum[BYTE_W-1];
    if (arith_op) begin
      if (use_word) begin
        calc   = w_sum;
        calc_n = w_sum[DATA_W-1];
      end
      nx_ccr[FL_N] = calc_n;
      nx_ccr[FL_Z] = (calc == '0);
      nx_ccr[FL_V] = use_word ? w_v : b_v;
      if (!keeps_ch) begin
        nx_ccr[FL_C] = use_word ? w_c : b_c;
        nx_ccr[FL_H] = use_word ? w_h : b_h;
      end
      nx_res = (op == OP_CMP) ? in_a : calc;
    end else if (op == OP_ADDS || op == OP_SUBS) begin
      nx_res = imm_res;
    end else if (op == OP_DAA || op == OP_DAS) begin
      nx_res       = {{(DATA_W-BYTE_W){1'b0}}, d_res};
      nx_ccr[FL_N] = d_res[BYTE_W-1];
      nx_ccr[FL_Z] = (d_res == '0);
      nx_ccr[FL_C] = d_c;
    end else begin
      nx_res       = {{(DATA_W-BYTE_W){1'b0}}, l_res};
      nx_ccr[FL_N] = l_res[BYTE_W-1];
      nx_ccr[FL_Z] = (l_res == '0);
      nx_ccr[FL_V] = 1'b0;
    end
  end

  logic accept;
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_ccr    <= '0;
    end else if (accept) begin
      out_valid  <= 1'b1;
      out_result <= nx_res;
      out_ccr    <= nx_ccr;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

// File: rtl/alu_flags_unit_chk.sv
module alu_flags_unit_chk
  import alu_flags_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [3:0]        in_op,
  input logic              in_word,
  input logic [DATA_W-1:0] in_a,
  input logic [DATA_W-1:0] in_b,
  input logic [FLAG_W-1:0] in_ccr,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic [FLAG_W-1:0] out_ccr
);
  logic acc;
  assign acc = in_valid && in_ready;

  p_hold_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_ccr)));

  p_accept_fills_r1: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  p_mask_bits_r13: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (out_ccr[FL_I] == $past(in_ccr[FL_I]) && out_ccr[FL_U1] == $past(in_ccr[FL_U1])
             && out_ccr[FL_U0] == $past(in_ccr[FL_U0])));

  p_zero_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op != 4'd6 && in_op != 4'd7 && in_op != 4'd8)
      |=> (out_ccr[FL_Z] == (out_result == '0)));

  p_imm_noflags_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (in_op == 4'd6 || in_op == 4'd7)) |=> (out_ccr == $past(in_ccr)));

  p_cmp_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op == 4'd8) |=> (out_result == $past(in_a)));

  p_logic_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op >= 4'd10 && in_op <= 4'd13)
      |=> (!out_ccr[FL_V] && out_ccr[FL_C] == $past(in_ccr[FL_C])
           && out_ccr[FL_H] == $past(in_ccr[FL_H])));
endmodule

bind alu_flags_unit alu_flags_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .in_word(in_word), .in_a(in_a), .in_b(in_b), .in_ccr(in_ccr),
  .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
  .out_ccr(out_ccr)
);

// File: tb/alu_flags_unit_tb_top.sv
module alu_flags_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  in_op = '0;
  logic        in_word = 1'b0;
  logic [15:0] in_a = '0, in_b = '0;
  logic [7:0]  in_ccr = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_result;
  logic [7:0]  out_ccr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_flags_unit dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_word(in_word), .in_a(in_a), .in_b(in_b), .in_ccr(in_ccr),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_ccr(out_ccr)
  );

  function automatic string tag_of(input int op);
    case (op)
      0, 1:        return "R3";
      2, 3:        return "R6";
      4, 5:        return "R7";
      6, 7:        return "R12";
      8:           return "R8";
      9:           return "R9";
      10, 11, 12, 13: return "R10";
      default:     return "R11";
    endcase
  endfunction

  function automatic int sext(input int x, input int mask);
    return (x > (mask >> 1)) ? x - mask - 1 : x;
  endfunction

  // Arithmetic model of the requirements
  function automatic void model(input int op, input bit wd, input int a, input int b,
                                input int f, output logic [15:0] r, output logic [7:0] nf);
    int mask, lm, msb, x, y, cin, s, res, sr;
    bit sub, c, h, v;
    nf = 8'(f);
    r  = '0;
    case (op)
      0, 1, 2, 3, 4, 5, 8, 9: begin
        bit big;
        big  = wd && (op == 0 || op == 1 || op == 8);
        mask = big ? 65535 : 255;
        lm   = big ? 4095 : 15;
        msb  = big ? 15 : 7;
        x = a & mask; y = b & mask; cin = 0; sub = 0;
        case (op)
          1, 8: sub = 1;
          2: cin = f & 1;
          3: begin sub = 1; cin = f & 1; end
          4: y = 1;
          5: begin sub = 1; y = 1; end
          9: begin sub = 1; x = 0; y = a & mask; end
          default: ;
        endcase
        if (sub) begin
          s  = x - y - cin;
          c  = x < y + cin;
          h  = (x & lm) < (y & lm) + cin;
          sr = sext(x, mask) - sext(y, mask) - cin;
        end else begin
          s  = x + y + cin;
          c  = s > mask;
          h  = (x & lm) + (y & lm) + cin > lm;
          sr = sext(x, mask) + sext(y, mask) + cin;
        end
        v   = (sr > (mask >> 1)) || (sr < -((mask >> 1) + 1));
        res = s & mask;
        nf[3] = ((res >> msb) & 1) != 0;
        nf[2] = (res == 0);
        nf[1] = v;
        if (op != 4 && op != 5) begin
          nf[0] = c;
          nf[5] = h;
        end
        r = (op == 8) ? 16'(a) : 16'(res);
      end
      6, 7: begin
        int st;
        st = ((b & 2) != 0) ? 2 : 1;
        r  = (op == 6) ? 16'((a + st) & 65535) : 16'((a - st) & 65535);
      end
      10, 11, 12, 13: begin
        case (op)
          10: res = a & b & 255;
          11: res = (a | b) & 255;
          12: res = (a ^ b) & 255;
          default: res = (~a) & 255;
        endcase
        r = 16'(res);
        nf[3] = (res & 128) != 0;
        nf[2] = (res == 0);
        nf[1] = 1'b0;
      end
      default: begin
        int adj, av;
        bit cc;
        av = a & 255; adj = 0; cc = (f & 1) != 0;
        if (op == 14) begin
          if ((f & 32) != 0 || (av & 15) > 9) adj += 6;
          if ((f & 1) != 0 || av > 153) begin adj += 96; cc = 1; end
          res = (av + adj) & 255;
        end else begin
          if ((f & 32) != 0) adj += 6;
          if ((f & 1) != 0) adj += 96;
          res = (av - adj) & 255;
        end
        r = 16'(res);
        nf[3] = (res & 128) != 0;
        nf[2] = (res == 0);
        nf[0] = cc;
      end
    endcase
  endfunction

  task automatic run_one(input int op, input bit wd, input int a, input int b, input int f);
    logic [15:0] er;
    logic [7:0]  ef;
    model(op, wd, a, b, f, er, ef);
    @(negedge clk);
    in_op = 4'(op); in_word = wd; in_a = 16'(a); in_b = 16'(b); in_ccr = 8'(f);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (out_valid !== 1'b1 || out_result !== er || out_ccr !== ef) begin
      errors++;
      if (errors <= 20)
        $display("FAIL %s op=%0d word=%0d a=%h b=%h ccr=%h: got valid=%b res=%h ccr=%h, expected valid=1 res=%h ccr=%h",
                 tag_of(op), op, wd, a[15:0], b[15:0], f[7:0], out_valid, out_result, out_ccr, er, ef);
    end
  endtask

  task automatic check_bit(input string tag, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", tag, what, got, exp);
    end
  endtask

  task automatic check_val(input string tag, input string what, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int bvals[12] = '{0, 1, 'h0F, 'h10, 'h7F, 'h80, 'h81, 'hFF, 'h09, 'h99, 'h55, 'hAA};
    int wvals[10] = '{0, 1, 'h0FFF, 'h1000, 'h7FFF, 'h8000, 'hFFFF, 'h8001, 'h00FF, 'h1234};
    int fvals[4]  = '{'h00, 'h21, 'hD0, 'hFF};

    repeat (3) @(negedge clk);
    // Reset state (R1)
    check_bit("R1", "out_valid in reset", out_valid, 1'b0);
    check_val("R1", "out_result in reset", out_result, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R1", "in_ready when empty", in_ready, 1'b1);

    // Byte sweep over all operations (R2..R13)
    for (int op = 0; op < 16; op++)
      for (int a8 = 0; a8 < 256; a8 += 7)
        for (int bi = 0; bi < 12; bi++)
          for (int fi = 0; fi < 4; fi++)
            run_one(op, 1'b0, ((a8 * 37) & 255) << 8 | a8,
                    ((bvals[bi] * 53) & 255) << 8 | bvals[bi], fvals[fi]);

    // Word corners: size select, half-carry at bit 11 (R4), step forms (R12)
    for (int op = 0; op < 16; op++)
      for (int ai = 0; ai < 10; ai++)
        for (int bi = 0; bi < 10; bi++)
          for (int fi = 1; fi < 3; fi++)
            run_one(op, 1'b1, wvals[ai], wvals[bi], fvals[fi]);

    // Exhaustive decimal adjust (R11)
    for (int op = 14; op < 16; op++)
      for (int a8 = 0; a8 < 256; a8++)
        for (int fi = 0; fi < 4; fi++)
          run_one(op, 1'b0, a8, 0, fvals[fi]);

    // Back-pressure and same-edge drain/accept (R1)
    @(negedge clk);
    out_ready = 1'b0;
    in_op = 4'd0; in_word = 1'b0; in_a = 16'h0001; in_b = 16'h0002; in_ccr = 8'h00;
    in_valid = 1'b1;
    @(negedge clk);
    check_bit("R1", "out_valid after accept", out_valid, 1'b1);
    check_bit("R1", "in_ready while stalled", in_ready, 1'b0);
    in_op = 4'd1; in_a = 16'h0005; in_b = 16'h0003;
    @(negedge clk);
    @(negedge clk);
    check_val("R1", "stalled result held", out_result, 16'h0003);
    check_bit("R1", "still valid while stalled", out_valid, 1'b1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check_bit("R1", "valid after drain+accept", out_valid, 1'b1);
    check_val("R1", "second result after drain+accept", out_result, 16'h0002);
    @(negedge clk);
    check_bit("R1", "empty after final drain", out_valid, 1'b0);

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule